// File: doc/BRIEF.md
# Class-Aware Non-Maximum Suppression Engine

This block reduces a buffer of candidate detection boxes to the short list that survives non-maximum suppression. Each entry holds two corner points, a class tag and a confidence value. Entries are written one per cycle through an indexed write port. When an entry is written, its confidence is compared with the confidence threshold. An entry below the threshold is flagged as unusable at that point and takes no further part in any overlap work.

A start pulse launches the selection loop. Each round picks the live entry with the highest confidence and presents it on a valid/ready output stream. The next pass then tests the winner against every remaining live entry of the same class. Any such entry whose overlap ratio exceeds the IoU threshold is retired. Entries of other classes are passed over without arithmetic. The same pass also finds the winner of the following round. The loop stops when nothing live remains or when ten boxes have been kept. A one-cycle done pulse then closes the run.

The overlap test needs no divider. The threshold is an 8-bit fraction (value/256), and the test compares the intersection scaled by 256 against the threshold times the union.

Top module: `nms_engine`

## Requirements
- R1: A write with `wr_en` high while idle stores the box at `wr_idx`. The entry becomes usable only if `wr_conf >= conf_thr` at that cycle. An unusable entry is never output and never suppresses another entry.
- R2: Each kept box is the live entry with the highest confidence at the start of its round, so within one run the output confidences never increase.
- R3: Among live entries of equal confidence, the one with the lower buffer index is output first.
- R4: An entry B of the same class as the kept box A is retired when inter×256 > iou_thr×(areaA + areaB − inter). Width is x2−x1 and height is y2−y1. A ratio exactly equal to the threshold does not retire.
- R5: An entry whose class differs from the kept box is never retired by it, however large the overlap.
- R6: The intersection is clamped to zero when the boxes are disjoint or only touch on an edge, so such boxes never suppress each other, even with `iou_thr` = 0.
- R7: At most 10 boxes are output per run. The run ends after the tenth accepted box even if live entries remain.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and every output field hold their values.
- R9: `done` is a single-cycle pulse, never high together with `out_valid`. It comes after the last accepted box, and it is low out of reset.
- R10: A start with no usable entry in the buffer raises `done` in the cycle after start and outputs nothing.
- R11: Writes and start pulses that arrive while a run is in progress have no effect. A new start, without reloading, repeats the same result, because the per-run retire flags are cleared at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Box write strobe (ignored while busy) |
| wr_idx | input | 6 | Buffer slot to write |
| wr_x1 | input | 16 | Left edge |
| wr_y1 | input | 16 | Top edge |
| wr_x2 | input | 16 | Right edge (>= wr_x1) |
| wr_y2 | input | 16 | Bottom edge (>= wr_y1) |
| wr_cls | input | 4 | Class tag |
| wr_conf | input | 8 | Confidence |
| conf_thr | input | 8 | Confidence threshold applied at write time |
| iou_thr | input | 8 | IoU threshold as a fraction of 256 |
| start | input | 1 | Launch a run (ignored while busy) |
| out_valid | output | 1 | Kept box available |
| out_ready | input | 1 | Consumer accepts the kept box |
| out_idx | output | 6 | Buffer slot of the kept box |
| out_x1 | output | 16 | Kept box left edge |
| out_y1 | output | 16 | Kept box top edge |
| out_x2 | output | 16 | Kept box right edge |
| out_y2 | output | 16 | Kept box bottom edge |
| out_cls | output | 4 | Kept box class tag |
| out_conf | output | 8 | Kept box confidence |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A kept box appears one pass of 64 cycles after start or after the previous acceptance. `done` follows the end of the final pass by one cycle, or follows the start edge by one cycle when the buffer holds nothing usable. Rather than predicting pass lengths, the bench samples at each falling edge. It records a box only when `out_valid` and the `out_ready` it has just driven will meet at the next rising edge, and it ends the run at the first falling edge that shows `done`. For an empty buffer it requires `done` at exactly the first falling edge after start. At the following falling edge it requires `done` to be low again.

// File: rtl/nms_pkg.sv
package nms_pkg;
  localparam int COORD_W = 16;
  localparam int CLASS_W = 4;
  localparam int CONF_W  = 8;
  localparam int THR_W   = 8;

  typedef struct packed {
    logic [COORD_W-1:0] x1;
    logic [COORD_W-1:0] y1;
    logic [COORD_W-1:0] x2;
    logic [COORD_W-1:0] y2;
  } rect_t;

  typedef struct packed {
    rect_t              geo;
    logic [CLASS_W-1:0] cls;
    logic [CONF_W-1:0]  conf;
  } box_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_EMIT = 2'd2,
    ST_DONE = 2'd3
  } nms_state_t;
endpackage

// File: rtl/nms_box_store.sv
module nms_box_store
  import nms_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  box_t              wr_box,
  input  logic [CONF_W-1:0] conf_thr,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output box_t              rd_a_box,
  output box_t              rd_b_box,
  output logic [DEPTH-1:0]  usable
);
  box_t             mem [DEPTH];
  logic [DEPTH-1:0] usable_q, usable_d;

  // payload storage: no reset, written only through the enable
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_box;
  end

  // confidence gate evaluated once, at write time
  always_comb begin
    usable_d = usable_q;
    if (wr_en) usable_d[wr_idx] = (wr_box.conf >= conf_thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) usable_q <= '0;
    else        usable_q <= usable_d;
  end

  assign rd_a_box = mem[rd_a_idx];
  assign rd_b_box = mem[rd_b_idx];
  assign usable   = usable_q;
endmodule

// File: rtl/nms_overlap.sv
module nms_overlap
  import nms_pkg::*;
(
  input  rect_t            a,
  input  rect_t            b,
  input  logic [THR_W-1:0] iou_thr,
  output logic             exceeds
);
  localparam int AREA_W = 2 * COORD_W;
  localparam int UNI_W  = AREA_W + 1;
  localparam int CMP_W  = UNI_W + THR_W;

  logic [COORD_W-1:0] lo_x, hi_x, lo_y, hi_y, iw, ih;
  logic [AREA_W-1:0]  inter, area_a, area_b;
  logic [UNI_W-1:0]   uni;
  logic [CMP_W-1:0]   lhs, rhs;

  always_comb begin
    lo_x   = (a.x1 > b.x1) ? a.x1 : b.x1;
    hi_x   = (a.x2 < b.x2) ? a.x2 : b.x2;
    lo_y   = (a.y1 > b.y1) ? a.y1 : b.y1;
    hi_y   = (a.y2 < b.y2) ? a.y2 : b.y2;
    iw     = (hi_x > lo_x) ? (hi_x - lo_x) : '0;
    ih     = (hi_y > lo_y) ? (hi_y - lo_y) : '0;
    inter  = AREA_W'(iw) * AREA_W'(ih);
    area_a = AREA_W'(a.x2 - a.x1) * AREA_W'(a.y2 - a.y1);
    area_b = AREA_W'(b.x2 - b.x1) * AREA_W'(b.y2 - b.y1);
    uni    = UNI_W'(area_a) + UNI_W'(area_b) - UNI_W'(inter);
    lhs    = CMP_W'(inter) << THR_W;
    rhs    = CMP_W'(iou_thr) * CMP_W'(uni);
    exceeds = (lhs > rhs);
  end
endmodule

// File: rtl/nms_ctrl.sv
module nms_ctrl
  import nms_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int MAX_KEEP = 10,
  parameter int IDX_W    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               any_usable,
  input  logic [DEPTH-1:0]   usable,
  input  logic [CLASS_W-1:0] scan_cls,
  input  logic [CONF_W-1:0]  scan_conf,
  input  logic [CLASS_W-1:0] sel_cls,
  input  logic               overlap_hi,
  input  logic               out_ready,
  output logic [IDX_W-1:0]   scan_idx,
  output logic [IDX_W-1:0]   sel_idx,
  output logic               idle,
  output logic               emit,
  output logic               done
);
  localparam int               KEEP_W   = $clog2(MAX_KEEP + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);
  localparam logic [KEEP_W-1:0] KEEP_LAST = KEEP_W'(MAX_KEEP - 1);

  nms_state_t         state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [IDX_W-1:0]   sel_q, sel_d;
  logic [IDX_W-1:0]   best_q, best_d;
  logic [CONF_W-1:0]  best_conf_q, best_conf_d;
  logic               found_q, found_d;
  logic               have_sel_q, have_sel_d;
  logic [DEPTH-1:0]   retired_q, retired_d;
  logic [KEEP_W-1:0]  kept_q, kept_d;

  logic alive, kill, better;

  always_comb begin
    alive  = usable[idx_q] & ~retired_q[idx_q];
    // class gate first: overlap result only matters for same-class entries
    kill   = have_sel_q & alive & (scan_cls == sel_cls) & overlap_hi;
    better = alive & ~kill & (~found_q | (scan_conf > best_conf_q));
  end

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    sel_d       = sel_q;
    best_d      = best_q;
    best_conf_d = best_conf_q;
    found_d     = found_q;
    have_sel_d  = have_sel_q;
    retired_d   = retired_q;
    kept_d      = kept_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (any_usable) begin
            state_d    = ST_SCAN;
            idx_d      = '0;
            found_d    = 1'b0;
            have_sel_d = 1'b0;
            retired_d  = '0;
            kept_d     = '0;
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      ST_SCAN: begin
        if (kill) retired_d[idx_q] = 1'b1;
        if (better) begin
          best_d      = idx_q;
          best_conf_d = scan_conf;
          found_d     = 1'b1;
        end
        if (idx_q == IDX_LAST) begin
          if (found_d) begin
            state_d = ST_EMIT;
            sel_d   = best_d;
          end else begin
            state_d = ST_DONE;
          end
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_EMIT: begin
        if (out_ready) begin
          retired_d[sel_q] = 1'b1;
          kept_d           = kept_q + 1'b1;
          if (kept_q == KEEP_LAST) begin
            state_d = ST_DONE;
          end else begin
            state_d    = ST_SCAN;
            idx_d      = '0;
            found_d    = 1'b0;
            have_sel_d = 1'b1;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      sel_q       <= '0;
      best_q      <= '0;
      best_conf_q <= '0;
      found_q     <= 1'b0;
      have_sel_q  <= 1'b0;
      retired_q   <= '0;
      kept_q      <= '0;
    end else begin
      state_q     <= state_d;
      idx_q       <= idx_d;
      sel_q       <= sel_d;
      best_q      <= best_d;
      best_conf_q <= best_conf_d;
      found_q     <= found_d;
      have_sel_q  <= have_sel_d;
      retired_q   <= retired_d;
      kept_q      <= kept_d;
    end
  end

  assign scan_idx = idx_q;
  assign sel_idx  = sel_q;
  assign idle     = (state_q == ST_IDLE);
  assign emit     = (state_q == ST_EMIT);
  assign done     = (state_q == ST_DONE);
endmodule

// File: rtl/nms_engine.sv
module nms_engine
  import nms_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int MAX_KEEP = 10,
  parameter int IDX_W    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [COORD_W-1:0] wr_x1,
  input  logic [COORD_W-1:0] wr_y1,
  input  logic [COORD_W-1:0] wr_x2,
  input  logic [COORD_W-1:0] wr_y2,
  input  logic [CLASS_W-1:0] wr_cls,
  input  logic [CONF_W-1:0]  wr_conf,
  input  logic [CONF_W-1:0]  conf_thr,
  input  logic [THR_W-1:0]   iou_thr,
  input  logic               start,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [IDX_W-1:0]   out_idx,
  output logic [COORD_W-1:0] out_x1,
  output logic [COORD_W-1:0] out_y1,
  output logic [COORD_W-1:0] out_x2,
  output logic [COORD_W-1:0] out_y2,
  output logic [CLASS_W-1:0] out_cls,
  output logic [CONF_W-1:0]  out_conf,
  output logic               done
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  box_t             wr_box, scan_box, sel_box;
  logic [DEPTH-1:0] usable;
  logic             any_usable;
  logic [IDX_W-1:0] scan_idx, sel_idx;
  logic             ctrl_idle, overlap_hi, store_we;

  always_comb begin
    wr_box.geo.x1 = wr_x1;
    wr_box.geo.y1 = wr_y1;
    wr_box.geo.x2 = wr_x2;
    wr_box.geo.y2 = wr_y2;
    wr_box.cls    = wr_cls;
    wr_box.conf   = wr_conf;
  end

  assign store_we   = wr_en & ctrl_idle;
  assign any_usable = |usable;

  nms_box_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (store_we),
    .wr_idx   (wr_idx),
    .wr_box   (wr_box),
    .conf_thr (conf_thr),
    .rd_a_idx (scan_idx),
    .rd_b_idx (sel_idx),
    .rd_a_box (scan_box),
    .rd_b_box (sel_box),
    .usable   (usable)
  );

  nms_overlap u_overlap (
    .a       (sel_box.geo),
    .b       (scan_box.geo),
    .iou_thr (iou_thr),
    .exceeds (overlap_hi)
  );

  nms_ctrl #(.DEPTH(DEPTH), .MAX_KEEP(MAX_KEEP), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .any_usable (any_usable),
    .usable     (usable),
    .scan_cls   (scan_box.cls),
    .scan_conf  (scan_box.conf),
    .sel_cls    (sel_box.cls),
    .overlap_hi (overlap_hi),
    .out_ready  (out_ready),
    .scan_idx   (scan_idx),
    .sel_idx    (sel_idx),
    .idle       (ctrl_idle),
    .emit       (out_valid),
    .done       (done)
  );

  assign out_idx  = sel_idx;
  assign out_x1   = sel_box.geo.x1;
  assign out_y1   = sel_box.geo.y1;
  assign out_x2   = sel_box.geo.x2;
  assign out_y2   = sel_box.geo.y2;
  assign out_cls  = sel_box.cls;
  assign out_conf = sel_box.conf;
endmodule

// File: rtl/nms_engine_chk.sv
module nms_engine_chk
  import nms_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int MAX_KEEP = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              out_valid,
  input logic              out_ready,
  input logic [IDX_W-1:0]  out_idx,
  input logic [CONF_W-1:0] out_conf,
  input logic              done,
  input logic              ctrl_idle,
  input logic              any_usable
);
  localparam int CNT_W = $clog2(MAX_KEEP + 1);

  logic [CNT_W-1:0]  acc_cnt_q;
  logic [CONF_W-1:0] last_conf_q;
  logic              have_last_q;
  logic              hs;

  assign hs = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt_q   <= '0;
      last_conf_q <= '0;
      have_last_q <= 1'b0;
    end else if (done) begin
      acc_cnt_q   <= '0;
      have_last_q <= 1'b0;
    end else if (hs) begin
      acc_cnt_q   <= acc_cnt_q + 1'b1;
      last_conf_q <= out_conf;
      have_last_q <= 1'b1;
    end
  end

  // R8: stalled output holds
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_idx) && $stable(out_conf));

  // R2: confidences never rise within a run
  a_r2_conf_order: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && have_last_q |-> out_conf <= last_conf_q);

  // R7: never offer more than the keep limit
  a_r7_keep_limit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> acc_cnt_q < CNT_W'(MAX_KEEP));

  // R9: done is a lone pulse, exclusive with valid
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  // R10: empty buffer finishes at once
  a_r10_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_idle && start && !any_usable |=> done && !out_valid);
endmodule

bind nms_engine nms_engine_chk #(.IDX_W(IDX_W), .MAX_KEEP(MAX_KEEP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start      (start),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_idx    (out_idx),
  .out_conf   (out_conf),
  .done       (done),
  .ctrl_idle  (ctrl_idle),
  .any_usable (any_usable)
);

// File: tb/tb_nms_engine.sv
module tb_nms_engine;
  import nms_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int MAX_KEEP   = 10;
  localparam int IDX_W      = $clog2(DEPTH);

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic               rst_n, wr_en, start, out_valid, out_ready, done;
  logic [IDX_W-1:0]   wr_idx, out_idx;
  logic [COORD_W-1:0] wr_x1, wr_y1, wr_x2, wr_y2, out_x1, out_y1, out_x2, out_y2;
  logic [CLASS_W-1:0] wr_cls, out_cls;
  logic [CONF_W-1:0]  wr_conf, out_conf, conf_thr;
  logic [THR_W-1:0]   iou_thr;

  nms_engine dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_x1(wr_x1), .wr_y1(wr_y1), .wr_x2(wr_x2), .wr_y2(wr_y2),
    .wr_cls(wr_cls), .wr_conf(wr_conf), .conf_thr(conf_thr), .iou_thr(iou_thr),
    .start(start), .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
    .out_x1(out_x1), .out_y1(out_y1), .out_x2(out_x2), .out_y2(out_y2),
    .out_cls(out_cls), .out_conf(out_conf), .done(done)
  );

  int total = 0;
  int bad   = 0;

  int m_x1 [DEPTH];
  int m_y1 [DEPTH];
  int m_x2 [DEPTH];
  int m_y2 [DEPTH];
  int m_cls[DEPTH];
  int m_conf[DEPTH];
  bit m_ok [DEPTH];
  int exp_list[MAX_KEEP];
  int exp_n;
  int got_list[DEPTH];
  int got_n;
  int done_cyc;

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic bit m_over(int i, int j, int thr);
    longint lx, hx, ly, hy, iw, ih, inter, aa, ab;
    lx = (m_x1[i] > m_x1[j]) ? m_x1[i] : m_x1[j];
    hx = (m_x2[i] < m_x2[j]) ? m_x2[i] : m_x2[j];
    ly = (m_y1[i] > m_y1[j]) ? m_y1[i] : m_y1[j];
    hy = (m_y2[i] < m_y2[j]) ? m_y2[i] : m_y2[j];
    iw = (hx > lx) ? hx - lx : 0;
    ih = (hy > ly) ? hy - ly : 0;
    inter = iw * ih;
    aa = longint'(m_x2[i] - m_x1[i]) * longint'(m_y2[i] - m_y1[i]);
    ab = longint'(m_x2[j] - m_x1[j]) * longint'(m_y2[j] - m_y1[j]);
    return (inter * 256) > (longint'(thr) * (aa + ab - inter));
  endfunction

  task automatic model_run(int thr);
    bit gone[DEPTH];
    int best;
    for (int k = 0; k < DEPTH; k++) gone[k] = 1'b0;
    exp_n = 0;
    while (exp_n < MAX_KEEP) begin
      best = -1;
      for (int k = 0; k < DEPTH; k++)
        if (m_ok[k] && !gone[k] && (best < 0 || m_conf[k] > m_conf[best])) best = k;
      if (best < 0) break;
      exp_list[exp_n] = best;
      exp_n++;
      gone[best] = 1'b1;
      for (int k = 0; k < DEPTH; k++)
        if (m_ok[k] && !gone[k] && m_cls[k] == m_cls[best] && m_over(best, k, thr))
          gone[k] = 1'b1;
    end
  endtask

  task automatic load_box(int idx, int x1, int y1, int x2, int y2, int cls, int conf);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_idx  = IDX_W'(idx);
    wr_x1   = COORD_W'(x1);
    wr_y1   = COORD_W'(y1);
    wr_x2   = COORD_W'(x2);
    wr_y2   = COORD_W'(y2);
    wr_cls  = CLASS_W'(cls);
    wr_conf = CONF_W'(conf);
    m_x1[idx] = x1; m_y1[idx] = y1; m_x2[idx] = x2; m_y2[idx] = y2;
    m_cls[idx] = cls; m_conf[idx] = conf;
    m_ok[idx]  = (conf >= int'(conf_thr));
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_all();
    conf_thr = 8'd1;
    for (int k = 0; k < DEPTH; k++) load_box(k, 0, 0, 0, 0, 0, 0);
  endtask

  // run once; optionally inject a write and a start while busy (R11)
  task automatic run_and_check(string req, int ready_pct, bit inject);
    int  cyc;
    bit  seen;
    model_run(int'(iou_thr));
    got_n = 0;
    seen  = 1'b0;
    cyc   = 0;
    @(negedge clk);
    start = 1'b1;
    while (cyc < 20000) begin
      @(negedge clk);
      start = 1'b0;
      wr_en = 1'b0;
      cyc++;
      if (inject && cyc == 3) begin
        wr_en = 1'b1; wr_idx = '0;
        wr_x1 = '0; wr_y1 = '0; wr_x2 = 16'd100; wr_y2 = 16'd100;
        wr_cls = '0; wr_conf = 8'd255;
        start = 1'b1;
      end
      if (done) begin
        seen = 1'b1;
        done_cyc = cyc;
        break;
      end
      out_ready = ($urandom_range(99, 0) < ready_pct);
      if (out_valid && out_ready) begin
        check(got_n < DEPTH, req, "too many outputs", got_n, exp_n);
        if (got_n < DEPTH) got_list[got_n] = int'(out_idx);
        got_n++;
        check(int'(out_conf) == m_conf[out_idx], req, "out_conf", out_conf, m_conf[out_idx]);
        check(int'(out_x1) == m_x1[out_idx] && int'(out_y2) == m_y2[out_idx]
              && int'(out_cls) == m_cls[out_idx], req, "out fields x1", out_x1, m_x1[out_idx]);
      end
    end
    wr_en = 1'b0;
    out_ready = 1'b0;
    check(seen, req, "done seen", seen, 1);
    @(negedge clk);
    check(!done, "R9", "done single cycle", done, 0);
    check(got_n == exp_n, req, "kept count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      check(got_list[i] == exp_list[i], req, "kept index order", got_list[i], exp_list[i]);
  endtask

  task automatic load_random(int cmax, int wmax, int ncls);
    for (int k = 0; k < DEPTH; k++) begin
      int x1, y1;
      x1 = $urandom_range(cmax, 0);
      y1 = $urandom_range(cmax, 0);
      load_box(k, x1, y1, x1 + $urandom_range(wmax, 0), y1 + $urandom_range(wmax, 0),
               $urandom_range(ncls - 1, 0), $urandom_range(255, 0));
    end
  endtask

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd20250117);
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; start = 1'b0; out_ready = 1'b0;
    wr_idx = '0; wr_x1 = '0; wr_y1 = '0; wr_x2 = '0; wr_y2 = '0;
    wr_cls = '0; wr_conf = '0; conf_thr = 8'd1; iou_thr = 8'd128;
    for (int k = 0; k < DEPTH; k++) m_ok[k] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid && !done, "R9", "reset state valid|done", {out_valid, done}, 0);

    // R10: nothing usable after reset
    run_and_check("R10", 100, 1'b0);
    check(done_cyc == 1, "R10", "done latency", done_cyc, 1);

    // R1: threshold applied at write, equal passes, below never shows
    clear_all();
    conf_thr = 8'd100; iou_thr = 8'd0;
    load_box(0, 0, 0, 50, 50, 0, 99);
    load_box(1, 0, 0, 50, 50, 0, 100);
    load_box(2, 200, 200, 210, 210, 0, 120);
    run_and_check("R1", 100, 1'b0);

    // R3: equal confidences leave in index order (expect 2, 7, 40)
    clear_all();
    load_box(7, 0, 0, 5, 5, 1, 120);
    load_box(2, 50, 50, 60, 60, 1, 120);
    load_box(40, 100, 100, 110, 110, 1, 120);
    run_and_check("R3", 70, 1'b0);

    // R4: IoU exactly 0.5 at threshold 128 keeps, at 127 retires
    clear_all();
    load_box(0, 0, 0, 16, 16, 1, 200);
    load_box(1, 0, 0, 16, 8, 1, 100);
    iou_thr = 8'd128;
    run_and_check("R4", 100, 1'b0);
    check(got_n == 2, "R4", "equal ratio kept", got_n, 2);
    iou_thr = 8'd127;
    run_and_check("R4", 100, 1'b0);
    check(got_n == 1, "R4", "above ratio retired", got_n, 1);

    // R5: other class never retired
    load_box(1, 0, 0, 16, 16, 2, 100);
    iou_thr = 8'd0;
    run_and_check("R5", 100, 1'b0);
    check(got_n == 2, "R5", "cross-class kept", got_n, 2);

    // R6: touching edges do not overlap, one-unit overlap does
    clear_all();
    load_box(0, 0, 0, 10, 10, 3, 200);
    load_box(1, 10, 0, 20, 10, 3, 150);
    load_box(2, 0, 9, 10, 19, 3, 100);
    iou_thr = 8'd0;
    run_and_check("R6", 100, 1'b0);
    check(got_n == 2, "R6", "touching kept", got_n, 2);

    // R7: fifteen disjoint boxes, only ten leave
    clear_all();
    for (int k = 0; k < 15; k++) load_box(k + 3, k * 20, 0, k * 20 + 10, 10, 0, 10 + k * 7);
    iou_thr = 8'd64;
    run_and_check("R7", 60, 1'b0);
    check(got_n == MAX_KEEP, "R7", "keep limit", got_n, MAX_KEEP);

    // R2 / R8: random buffers with back-pressure
    for (int r = 0; r < 5; r++) begin
      conf_thr = CONF_W'($urandom_range(80, 0));
      iou_thr  = THR_W'($urandom_range(200, 20));
      load_random(120, 60, 3);
      run_and_check("R2", 100, 1'b0);
      run_and_check("R8", 25 + r * 10, 1'b0);
    end

    // R11: write and start during a run are dropped; rerun repeats
    conf_thr = 8'd30; iou_thr = 8'd90;
    load_random(150, 50, 2);
    run_and_check("R11", 80, 1'b1);
    run_and_check("R11", 80, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule